// File: doc/BRIEF.md
# Serial Port Control/Status Register Bank with Scoped Resets

This block holds the programmable state of a synchronous serial port: a protected configuration word, a combined control/status register that carries the port enable, a set of upper control bits and the status flags, and a clock-gate output for the transfer logic. Software reaches it over a simple single-cycle register bus. The transfer logic reports events on a pulse vector, and each pulse sets a sticky status flag.

Three resets act on the bank, and each reaches a different set of bits. The chip reset input returns everything to defaults, the enable included. Writing the enable bit to zero is a port-local reset: it clears every status flag and keeps all programmed control bits. Holding the stop request clears the status flags in the same way, keeps the control bits and gates the port clock off. The bank also enforces bring-up order. Control fields can be programmed only while the port is disabled. A write that breaks this rule is dropped and recorded as a configuration error. The enable is then set by a later, separate write.

Register map (word addresses): 0 = configuration word in bits [CFG_W-1:0]. 1 = combined register with enable at bit DW-1, upper control bits at [DW-2:DW/2], the configuration-error flag at bit DW/2-1 and the event flags at [NSTAT-1:0]. Addresses 2 and 3 read as zero and ignore writes.

Top module: `sport_ctl_regs`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `port_en`=0, `cfg_out`=CFG_RST, `ctl_out`=0, `clk_gate`=0, and every status flag reads 0.
- R2: A write to address 0 while `port_en`=0 updates `cfg_out` right after the write edge.
- R3: A write to address 0 while `port_en`=1 leaves `cfg_out` unchanged and sets the configuration-error flag (bit DW/2-1 of address 1).
- R4: A write to address 1 with bit DW-1 set while `port_en`=0 sets `port_en` and leaves `ctl_out` at the value it held before the write.
- R5: A write to address 1 with bit DW-1 clear while `port_en`=0 loads `ctl_out`. While `port_en`=1, a write that keeps the enable set cannot change `ctl_out`. It sets the configuration-error flag only when its control bits differ from `ctl_out`.
- R6: A write to address 1 with bit DW-1 clear drops `port_en` and clears every status flag at that edge, and it keeps `cfg_out` and `ctl_out`.
- R7: While `stop_req` is high, the status flags are held at 0, `clk_gate` is 0 after the next edge, and `port_en`, `cfg_out` and `ctl_out` keep their values.
- R8: `clk_gate` is the value of (`port_en` and not `stop_req`) registered at the previous edge. It rises on the first edge after stop is released with the port enabled, and it falls one edge after the port is disabled.
- R9: A high bit of `evt_in` at an edge where `port_en`=1 and `stop_req`=0 sets the matching sticky flag in bits [NSTAT-1:0] of address 1. Events are ignored while the port is disabled or stopped.
- R10: `rdata` shows the register selected at the edge where `rd_en` was high, one cycle later. Unused addresses read 0.
- R11: Chip reset clears the control state as well as the status state: a `port_en`, `cfg_out` and `ctl_out` that were programmed return to their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| stop_req | input | 1 | Low-power stop request (level) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| evt_in | input | NSTAT | Event pulses from the transfer logic |
| port_en | output | 1 | Port enable |
| cfg_out | output | CFG_W | Protected configuration word |
| ctl_out | output | DW/2-1 | Upper control bits |
| clk_gate | output | 1 | Port clock enable |

## Verification
Writes and resets act at the edge that samples them, so the bench checks `port_en`, `cfg_out` and `ctl_out` at the falling edge right after that edge. `clk_gate` passes through one more register, so the bench checks it both at the first falling edge after a change of enable or stop and at the falling edge that follows. Status flags are observed only through reads. A driver task queues the expected word when it raises `rd_en`, and a monitor compares `rdata` at the falling edge after the sampling edge. Reads are issued only after the write or event that they follow has been sampled.

// File: rtl/sport_ctl_pkg.sv
`timescale 1ns/1ps
package sport_ctl_pkg;
  localparam int unsigned SP_ADDR_CFG = 0;
  localparam int unsigned SP_ADDR_CSR = 1;
endpackage

// File: rtl/sport_ctl_cfg.sv
`timescale 1ns/1ps
// Control storage: configuration word, upper control bits and enable.
module sport_ctl_cfg #(
  parameter int unsigned CFG_W   = 8,
  parameter int unsigned HI_W    = 7,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cfg,
  input  logic             wr_csr,
  input  logic [CFG_W-1:0] cfg_wd,
  input  logic [HI_W-1:0]  hi_wd,
  input  logic             en_wd,
  output logic [CFG_W-1:0] cfg_q,
  output logic [HI_W-1:0]  hi_q,
  output logic             en_q,
  output logic             viol,
  output logic             local_rst
);
  always_comb begin
    viol = 1'b0;
    if (wr_cfg && en_q) viol = 1'b1;
    if (wr_csr && en_q && en_wd && (hi_wd != hi_q)) viol = 1'b1;
    local_rst = wr_csr && !en_wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RST;
      hi_q  <= '0;
      en_q  <= 1'b0;
    end else begin
      if (wr_cfg && !en_q) cfg_q <= cfg_wd;
      if (wr_csr) begin
        en_q <= en_wd;
        if (!en_q && !en_wd) hi_q <= hi_wd;
      end
    end
  end
endmodule

// File: rtl/sport_ctl_stat.sv
`timescale 1ns/1ps
// Sticky status flags with scoped clearing.
module sport_ctl_stat #(
  parameter int unsigned NSTAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             accept,
  input  logic [NSTAT-1:0] evt,
  input  logic             viol,
  output logic [NSTAT-1:0] flags_q,
  output logic             err_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flags_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (accept) flags_q <= flags_q | evt;
      if (viol)   err_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/sport_ctl_gate.sv
`timescale 1ns/1ps
// Registered clock enable for the transfer logic.
module sport_ctl_gate (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic stop,
  output logic gate_q
);
  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= en && !stop;
  end
endmodule

// File: rtl/sport_ctl_regs.sv
`timescale 1ns/1ps
module sport_ctl_regs
  import sport_ctl_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned AW      = 2,
  parameter int unsigned CFG_W   = 8,
  parameter int unsigned NSTAT   = 4,
  parameter logic [CFG_W-1:0] CFG_RST = 8'h1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NSTAT-1:0]  evt_in,
  output logic              port_en,
  output logic [CFG_W-1:0]  cfg_out,
  output logic [DW/2-2:0]   ctl_out,
  output logic              clk_gate
);
  localparam int unsigned HALF = DW / 2;
  localparam int unsigned HI_W = HALF - 1;
  localparam int unsigned PADW = HALF - 1 - NSTAT;

  logic             sel_cfg, sel_csr;
  logic             viol, local_rst;
  logic [NSTAT-1:0] flags_q;
  logic             err_q;
  logic [DW-1:0]    csr_view, cfg_view, rd_mux;

  assign sel_cfg = (addr == AW'(SP_ADDR_CFG));
  assign sel_csr = (addr == AW'(SP_ADDR_CSR));

  sport_ctl_cfg #(.CFG_W(CFG_W), .HI_W(HI_W), .CFG_RST(CFG_RST)) cfg_i (
    .clk(clk), .rst(rst),
    .wr_cfg(wr_en && sel_cfg), .wr_csr(wr_en && sel_csr),
    .cfg_wd(wdata[CFG_W-1:0]), .hi_wd(wdata[DW-2:HALF]), .en_wd(wdata[DW-1]),
    .cfg_q(cfg_out), .hi_q(ctl_out), .en_q(port_en),
    .viol(viol), .local_rst(local_rst)
  );

  sport_ctl_stat #(.NSTAT(NSTAT)) stat_i (
    .clk(clk), .rst(rst),
    .clr(stop_req || !port_en || local_rst),
    .accept(port_en && !stop_req),
    .evt(evt_in), .viol(viol),
    .flags_q(flags_q), .err_q(err_q)
  );

  sport_ctl_gate gate_i (
    .clk(clk), .rst(rst), .en(port_en), .stop(stop_req), .gate_q(clk_gate)
  );

  generate
    if (PADW > 0) begin : g_pad
      assign csr_view = {port_en, ctl_out, err_q, {PADW{1'b0}}, flags_q};
    end else begin : g_nopad
      assign csr_view = {port_en, ctl_out, err_q, flags_q};
    end
  endgenerate

  assign cfg_view = {{(DW-CFG_W){1'b0}}, cfg_out};

  always_comb begin
    rd_mux = '0;
    if (sel_cfg)      rd_mux = cfg_view;
    else if (sel_csr) rd_mux = csr_view;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/sport_ctl_chk.sv
`timescale 1ns/1ps
module sport_ctl_chk #(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 2,
  parameter int unsigned CFG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             stop_req,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic             port_en,
  input logic [CFG_W-1:0] cfg_out,
  input logic [DW/2-2:0]  ctl_out,
  input logic             clk_gate
);
  logic csr_wr;
  assign csr_wr = wr_en && (addr == AW'(1));

  // R3
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    port_en |=> $stable(cfg_out));
  // R5
  ctl_lock_chk: assert property (@(posedge clk) disable iff (rst)
    port_en |=> $stable(ctl_out));
  // R4
  ctl_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!port_en && csr_wr && wdata[DW-1]) |=> (port_en && $stable(ctl_out)));
  // R6
  disable_chk: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && !wdata[DW-1]) |=> !port_en);
  // R7
  stop_gate_chk: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !clk_gate);
  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> !clk_gate);
endmodule

bind sport_ctl_regs sport_ctl_chk #(.DW(DW), .AW(AW), .CFG_W(CFG_W)) chk_i (
  .clk(clk), .rst(rst), .stop_req(stop_req), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .port_en(port_en), .cfg_out(cfg_out), .ctl_out(ctl_out),
  .clk_gate(clk_gate)
);

// File: tb/sport_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module sport_ctl_regs_tb_top;
  localparam int unsigned DW = 16, AW = 2, CFG_W = 8, NSTAT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, stop_req = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NSTAT-1:0] evt_in = '0;
  logic port_en, clk_gate;
  logic [CFG_W-1:0] cfg_out;
  logic [DW/2-2:0] ctl_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  logic lat = 1'b0;

  always #2.5 clk = ~clk;

  sport_ctl_regs dut_i (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .evt_in(evt_in),
    .port_en(port_en), .cfg_out(cfg_out), .ctl_out(ctl_out), .clk_gate(clk_gate)
  );

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [NSTAT-1:0] v);
    @(negedge clk); evt_in = v;
    @(negedge clk); evt_in = '0;
  endtask

  // monitor: scoreboard side
  always @(posedge clk) lat <= rd_en;
  always @(negedge clk) begin
    if (lat) begin
      if (exp_q.size() == 0) ck("R10 unexpected read", 32'(rdata), 32'hDEAD);
      else ck(tag_q.pop_front(), 32'(rdata), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    ck("R1 port_en", 32'(port_en), 0);
    ck("R1 cfg_out", 32'(cfg_out), 32'h1F);
    ck("R1 ctl_out", 32'(ctl_out), 0);
    ck("R1 clk_gate", 32'(clk_gate), 0);
    rd(1, 16'h0000, "R1 csr read");
    rd(0, 16'h001F, "R1 cfg read");
    // R2 program while disabled
    wr(0, 16'h00A5);
    ck("R2 cfg_out", 32'(cfg_out), 32'hA5);
    rd(0, 16'h00A5, "R2 cfg read");
    // R5 control bits loaded while disabled
    wr(1, 16'h2A00);
    ck("R5 ctl load", 32'(ctl_out), 32'h2A);
    // R4 enable write keeps old control
    wr(1, 16'h9100);
    ck("R4 port_en", 32'(port_en), 1);
    ck("R4 ctl kept", 32'(ctl_out), 32'h2A);
    ck("R8 gate lag", 32'(clk_gate), 0);
    @(negedge clk);
    ck("R8 gate on", 32'(clk_gate), 1);
    // R9 events while enabled
    pulse(4'b0101);
    rd(1, 16'hAA05, "R9 flags set");
    // R3 protected write while enabled
    wr(0, 16'h003C);
    ck("R3 cfg held", 32'(cfg_out), 32'hA5);
    rd(1, 16'hAA85, "R3 err flag");
    wr(1, 16'hFF00);
    ck("R5 ctl locked", 32'(ctl_out), 32'h2A);
    // R7 stop
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk);
    ck("R7 gate off", 32'(clk_gate), 0);
    ck("R7 en kept", 32'(port_en), 1);
    ck("R7 cfg kept", 32'(cfg_out), 32'hA5);
    rd(1, 16'hAA00, "R7 status cleared");
    pulse(4'b1111);
    @(negedge clk); stop_req = 1'b0;
    @(negedge clk);
    ck("R8 gate after stop", 32'(clk_gate), 1);
    rd(1, 16'hAA00, "R9 ignored in stop");
    pulse(4'b1000);
    rd(1, 16'hAA08, "R9 flag after stop");
    // R6 port-local reset
    wr(1, 16'h2A00);
    ck("R6 en off", 32'(port_en), 0);
    ck("R8 gate lag off", 32'(clk_gate), 1);
    @(negedge clk);
    ck("R8 gate off", 32'(clk_gate), 0);
    ck("R6 cfg kept", 32'(cfg_out), 32'hA5);
    rd(1, 16'h2A00, "R6 status cleared");
    pulse(4'b1111);
    rd(1, 16'h2A00, "R9 ignored disabled");
    // R5 error only on differing control
    wr(1, 16'hAA00);
    wr(1, 16'hAA00);
    rd(1, 16'hAA00, "R5 same ctl no err");
    wr(1, 16'h8100);
    ck("R5 ctl locked 2", 32'(ctl_out), 32'h2A);
    rd(1, 16'hAA80, "R5 err on diff");
    // R10 unused address
    rd(2, 16'h0000, "R10 unused addr");
    // R11 chip reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    ck("R11 en", 32'(port_en), 0);
    ck("R11 cfg", 32'(cfg_out), 32'h1F);
    ck("R11 ctl", 32'(ctl_out), 0);
    rd(1, 16'h0000, "R11 csr");
    @(negedge clk);
    ck("R10 queue drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule